// File: doc/BRIEF.md
# Serial Save-Memory Command Responder

This block is the memory side of a byte-wide serial save-memory port. The host hands it one byte per transfer, together with a flag that says whether chip-select stays asserted after that byte. The block returns one response byte per transfer. A chain of transfers with the hold flag set forms a frame. The first byte of each frame is taken as a command. The data commands then collect a two-byte address for EEPROM-type memory or a three-byte address for flash-type memory. After the address, each further byte reads, programs or swaps one byte of an internal array, and the address advances after every access.

A write-enable latch lives in a status register. It gates every store. The array grows in power-of-two steps as accesses reach further into it, and bytes that have never been written read as 0xFF. Each transfer keeps the block busy for a fixed number of clock cycles, and the response is presented when busy drops.

Top module: `spi_save_responder`

## Requirements
- R1: After reset, `busy` is 0, `resp_byte` is 0xFF, the write-enable bit is clear, every array byte reads 0xFF, and the next byte accepted opens a new frame.
- R2: A pulse on `xfer_start` while `busy` is low is accepted. `busy` is high for exactly BYTE_CYCLES cycles starting on the next cycle. `resp_byte` changes only in the cycle where `busy` falls. A pulse while `busy` is high is ignored.
- R3: The first byte of a frame is latched as the command and clears the address register. Its response is 0xFF.
- R4: A transfer with `xfer_hold` low ends the frame, so the following accepted byte is a new command.
- R5: The data commands 0x02, 0x03 and 0x0A collect address bytes, each shifted into the low end of the address. Three bytes are collected when `mem_is_flash` was 1 with the command byte, otherwise two. Each address byte responds 0xFF. The array index is the address modulo MEM_DEPTH.
- R6: Command 0x06 sets status bit 1 (write enable) and command 0x04 clears it, both as the command byte is latched. Every later byte of a 0x05 frame returns the status byte, which has bit 1 equal to write enable and all other bits 0.
- R7: Each data byte of a 0x03 frame returns the array byte at the address and then increments the address.
- R8: Each data byte of a 0x02 frame responds 0xFF and increments the address. It stores the received byte only when write enable is set.
- R9: Each data byte of a 0x0A frame returns the old byte at the address and increments the address. It stores the received byte only when write enable is set.
- R10: Any other command responds 0xFF to all of its bytes and changes neither the array nor the status.
- R11: The array capacity is zero or a power of two and grows to cover each accessed index. Bytes that have never been written read 0xFF.
- R12: Write enable stays set across any number of stores until a 0x04 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | One-cycle pulse that offers a byte |
| xfer_byte | input | 8 | Byte sent by the host |
| xfer_hold | input | 1 | 1 keeps the frame open after this byte |
| mem_is_flash | input | 1 | Memory type taken with a command byte: 1 selects a 3-byte address |
| busy | output | 1 | High while a transfer is in progress |
| resp_byte | output | 8 | Response to the last completed transfer |

## Verification
An accepted byte is sampled on one rising edge, and `busy` reads high from the next cycle. `busy` then stays high for BYTE_CYCLES cycles. The response register and every state change land on the edge where `busy` falls.

The bench drives each byte on a falling edge and counts the falling edges at which `busy` is high, expecting BYTE_CYCLES of them. It compares `resp_byte` at the first falling edge with `busy` low. The expected values come from a byte-level model of the command rules.

// File: rtl/spisave_pkg.sv
package spisave_pkg;

    typedef enum logic [7:0] {
        OP_PROG   = 8'h02,
        OP_READ   = 8'h03,
        OP_WDIS   = 8'h04,
        OP_STAT   = 8'h05,
        OP_WEN    = 8'h06,
        OP_SWAP   = 8'h0A
    } op_e;

    typedef struct packed {
        logic [7:0] data;
        logic       hold;
        logic       flash;
    } xfer_t;

    localparam logic [7:0] IDLE_BYTE = 8'hFF;
    localparam int         ADDR_W    = 24;

    function automatic logic [1:0] addr_len(input logic flash);
        return flash ? 2'd3 : 2'd2;
    endfunction

    function automatic logic [7:0] status_byte(input logic wen);
        return {6'b0, wen, 1'b0};
    endfunction

    function automatic logic is_data_op(input logic [7:0] op);
        return (op == OP_PROG) || (op == OP_READ) || (op == OP_SWAP);
    endfunction

    function automatic int unsigned ceil_pow2(input int unsigned v);
        int unsigned p;
        p = 1;
        for (int i = 0; i < 31; i++) begin
            if (p < v) p = p << 1;
        end
        return p;
    endfunction

endpackage

// File: rtl/spisave_pacer.sv
module spisave_pacer #(
    parameter int BYTE_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(BYTE_CYCLES + 1);

    logic [CW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                cnt_q  <= CW'(BYTE_CYCLES - 1);
                busy_q <= 1'b1;
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = busy_q;
    assign done = busy_q && (cnt_q == '0);

    a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
    a_r2_busy_holds: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> busy);
endmodule

// File: rtl/spisave_store.sv
module spisave_store #(
    parameter int DEPTH = 256
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(DEPTH)-1:0] idx,
    input  logic                     touch,
    input  logic                     wr_en,
    input  logic [7:0]               wr_data,
    output logic [7:0]               rd_data
);
    import spisave_pkg::*;

    localparam int AW   = $clog2(DEPTH);
    localparam int CAPW = AW + 1;

    logic [7:0]      mem_q [DEPTH];
    logic [CAPW-1:0] cap_q;
    logic            beyond;

    assign beyond  = ({1'b0, idx} >= cap_q);
    assign rd_data = beyond ? IDLE_BYTE : mem_q[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= IDLE_BYTE;
        end else begin
            if (touch && beyond)
                cap_q <= CAPW'(ceil_pow2(32'(idx) + 32'd1));
            if (wr_en)
                mem_q[idx] <= wr_data;
        end
    end

    a_r11_cap_pow2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cap_q));
    a_r11_cap_covers: assert property (@(posedge clk) disable iff (rst)
        touch |=> ({1'b0, $past(idx)} < cap_q));
endmodule

// File: rtl/spisave_seq.sv
module spisave_seq #(
    parameter int DEPTH = 256
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       done,
    input  spisave_pkg::xfer_t         cur,
    input  logic [7:0]                 rd_data,
    output logic [$clog2(DEPTH)-1:0]   mem_idx,
    output logic                       touch,
    output logic                       wr_en,
    output logic [7:0]                 wr_data,
    output logic [7:0]                 resp_n
);
    import spisave_pkg::*;

    localparam int AW = $clog2(DEPTH);

    logic              open_q, open_n;
    logic [7:0]        cmd_q, cmd_n;
    logic [ADDR_W-1:0] addr_q, addr_n;
    logic [1:0]        left_q, left_n;
    logic              wen_q, wen_n;

    assign mem_idx = addr_q[AW-1:0];
    assign wr_data = cur.data;

    always_comb begin
        open_n = open_q;
        cmd_n  = cmd_q;
        addr_n = addr_q;
        left_n = left_q;
        wen_n  = wen_q;
        touch  = 1'b0;
        wr_en  = 1'b0;
        resp_n = IDLE_BYTE;
        if (done) begin
            open_n = cur.hold;
            if (!open_q) begin
                cmd_n  = cur.data;
                addr_n = '0;
                left_n = addr_len(cur.flash);
                if (cur.data == OP_WEN)  wen_n = 1'b1;
                if (cur.data == OP_WDIS) wen_n = 1'b0;
            end else if (cmd_q == OP_STAT) begin
                resp_n = status_byte(wen_q);
            end else if (is_data_op(cmd_q)) begin
                if (left_q != 2'd0) begin
                    addr_n = {addr_q[ADDR_W-9:0], cur.data};
                    left_n = left_q - 2'd1;
                end else begin
                    touch  = 1'b1;
                    addr_n = addr_q + 1'b1;
                    if (cmd_q != OP_PROG) resp_n = rd_data;
                    if (cmd_q != OP_READ) wr_en  = wen_q;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            cmd_q  <= '0;
            addr_q <= '0;
            left_q <= '0;
            wen_q  <= 1'b0;
        end else begin
            open_q <= open_n;
            cmd_q  <= cmd_n;
            addr_q <= addr_n;
            left_q <= left_n;
            wen_q  <= wen_n;
        end
    end

    // R12: write enable moves only when a transfer completes
    a_r12_wen_quiet: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable(wen_q));
endmodule

// File: rtl/spi_save_responder.sv
module spi_save_responder #(
    parameter int MEM_DEPTH   = 256,
    parameter int BYTE_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       xfer_start,
    input  logic [7:0] xfer_byte,
    input  logic       xfer_hold,
    input  logic       mem_is_flash,
    output logic       busy,
    output logic [7:0] resp_byte
);
    import spisave_pkg::*;

    localparam int AW = $clog2(MEM_DEPTH);

    xfer_t          cur_q;
    logic           done;
    logic [AW-1:0]  mem_idx;
    logic           touch, wr_en;
    logic [7:0]     wr_data, rd_data, resp_n, resp_q;

    spisave_pacer #(.BYTE_CYCLES(BYTE_CYCLES)) u_pacer (
        .clk(clk), .rst(rst), .start(xfer_start), .busy(busy), .done(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            resp_q <= IDLE_BYTE;
        end else begin
            if (xfer_start && !busy)
                cur_q <= '{data: xfer_byte, hold: xfer_hold, flash: mem_is_flash};
            if (done)
                resp_q <= resp_n;
        end
    end

    spisave_seq #(.DEPTH(MEM_DEPTH)) u_seq (
        .clk(clk), .rst(rst), .done(done), .cur(cur_q), .rd_data(rd_data),
        .mem_idx(mem_idx), .touch(touch), .wr_en(wr_en), .wr_data(wr_data),
        .resp_n(resp_n)
    );

    spisave_store #(.DEPTH(MEM_DEPTH)) u_store (
        .clk(clk), .rst(rst), .idx(mem_idx), .touch(touch), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data)
    );

    assign resp_byte = resp_q;

    a_r2_resp_on_fall: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(resp_byte));
endmodule

// File: tb/sim_spi_save_responder.sv
module sim_spi_save_responder;
    localparam int DEPTH = 256;
    localparam int NCYC  = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       xfer_start = 1'b0;
    logic [7:0] xfer_byte = '0;
    logic       xfer_hold = 1'b0;
    logic       mem_is_flash = 1'b0;
    logic       busy;
    logic [7:0] resp_byte;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit ended  = 0;

    logic [7:0]  m_mem [DEPTH];
    logic        m_open, m_wen;
    logic [7:0]  m_cmd;
    logic [23:0] m_addr;
    int          m_left;

    always #5 clk = ~clk;

    spi_save_responder #(.MEM_DEPTH(DEPTH), .BYTE_CYCLES(NCYC)) u0 (
        .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_byte(xfer_byte),
        .xfer_hold(xfer_hold), .mem_is_flash(mem_is_flash),
        .busy(busy), .resp_byte(resp_byte)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model(input logic [7:0] b, input logic h, input logic fl,
                         output logic [7:0] e);
        e = 8'hFF;
        if (!m_open) begin
            m_cmd  = b;
            m_addr = '0;
            m_left = fl ? 3 : 2;
            if (b == 8'h06) m_wen = 1'b1;
            if (b == 8'h04) m_wen = 1'b0;
        end else if (m_cmd == 8'h05) begin
            e = {6'b0, m_wen, 1'b0};
        end else if (m_cmd == 8'h02 || m_cmd == 8'h03 || m_cmd == 8'h0A) begin
            if (m_left != 0) begin
                m_addr = {m_addr[15:0], b};
                m_left--;
            end else begin
                if (m_cmd != 8'h02) e = m_mem[m_addr[7:0]];
                if (m_cmd != 8'h03 && m_wen) m_mem[m_addr[7:0]] = b;
                m_addr = m_addr + 24'd1;
            end
        end
        m_open = h;
    endtask

    task automatic xfer(input logic [7:0] b, input logic h, input logic fl,
                        input string tag, input bit poke = 1'b0);
        logic [7:0] e;
        int n;
        model(b, h, fl, e);
        @(negedge clk);
        xfer_start = 1'b1; xfer_byte = b; xfer_hold = h; mem_is_flash = fl;
        @(negedge clk);
        xfer_start = 1'b0;
        n = 0;
        while (busy && n < 1000) begin
            n++;
            if (poke && n == 1) begin
                xfer_start = 1'b1; xfer_byte = ~b; xfer_hold = ~h;
            end
            @(negedge clk);
            xfer_start = 1'b0;
        end
        check(n == NCYC, "R2 busy length", n, NCYC);
        check(resp_byte == e, tag, resp_byte, e);
    endtask

    task automatic send_addr(input logic [23:0] a, input logic fl, input string tag);
        if (fl) xfer(a[23:16], 1'b1, fl, tag);
        xfer(a[15:8], 1'b1, fl, tag);
        xfer(a[7:0], 1'b1, fl, tag);
    endtask

    task automatic burst(input logic [7:0] op, input logic [23:0] a, input logic fl,
                         input int len, input int seed, input string tag);
        xfer(op, 1'b1, fl, "R3 command byte");
        send_addr(a, fl, "R5 address byte");
        for (int i = 0; i < len; i++)
            xfer(8'((seed + i * 29) ^ (i >> 2)), (i != len - 1), fl, tag);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !ended) begin
            ended = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        m_open = 1'b0; m_wen = 1'b0; m_cmd = '0; m_addr = '0; m_left = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(resp_byte == 8'hFF, "R1 resp after reset", resp_byte, 8'hFF);

        // R1/R6: status reads clear
        xfer(8'h05, 1'b1, 1'b0, "R3 status cmd");
        xfer(8'h00, 1'b0, 1'b0, "R6 status after reset");
        // R11: never-written bytes read 0xFF, both address widths
        burst(8'h03, 24'h000080, 1'b0, 4, 0, "R11 fresh read eeprom");
        burst(8'h03, 24'h7F0010, 1'b1, 4, 0, "R11 fresh read flash");
        // R10: unknown command, no effect
        burst(8'h9C, 24'h000020, 1'b0, 3, 5, "R10 unknown command");
        xfer(8'h05, 1'b1, 1'b0, "R3 status cmd");
        xfer(8'h00, 1'b0, 1'b0, "R10 status unchanged");
        // R8: program without write enable stores nothing
        burst(8'h02, 24'h000010, 1'b0, 3, 9, "R8 program disabled");
        burst(8'h03, 24'h000010, 1'b0, 3, 0, "R8 readback after disabled program");
        // R6: enable then status
        xfer(8'h06, 1'b0, 1'b0, "R6 enable cmd");
        xfer(8'h05, 1'b1, 1'b1, "R3 status cmd");
        xfer(8'h11, 1'b1, 1'b1, "R6 status enabled");
        xfer(8'h22, 1'b0, 1'b1, "R6 status enabled repeat");
        // R11: single write then neighbour still 0xFF
        burst(8'h02, 24'h000005, 1'b0, 1, 77, "R8 program one");
        burst(8'h03, 24'h000004, 1'b0, 3, 0, "R11 neighbours of write");
        // sweep: program whole array in both address modes, read back
        for (int fl = 0; fl < 2; fl++) begin
            for (int base = 0; base < DEPTH; base += 32) begin
                burst(8'h02, {8'(fl * 8'h5A), 8'(base >> 3), 8'(base)}, fl[0], 32,
                      base * 3 + fl * 101, "R8 program sweep");
            end
            for (int base = 0; base < DEPTH; base += 64)
                burst(8'h03, {8'h00, 8'h33, 8'(base)}, fl[0], 64, 0, "R7 read sweep");
        end
        // R7/R5: auto-increment wraps across the top index
        burst(8'h03, 24'h0000FE, 1'b0, 4, 0, "R7 read wrap");
        // R12: enable survives all those stores
        xfer(8'h05, 1'b1, 1'b0, "R3 status cmd");
        xfer(8'h00, 1'b0, 1'b0, "R12 enable kept");
        // R9: swap with enable returns old, stores new
        burst(8'h0A, 24'h001040, 1'b1, 6, 200, "R9 swap enabled");
        burst(8'h03, 24'h000040, 1'b0, 6, 0, "R9 readback after swap");
        // R9 disabled: swap returns old and keeps it
        xfer(8'h04, 1'b0, 1'b0, "R6 disable cmd");
        burst(8'h0A, 24'h000040, 1'b0, 4, 3, "R9 swap disabled");
        burst(8'h03, 24'h000040, 1'b0, 4, 0, "R9 readback after disabled swap");
        xfer(8'h05, 1'b1, 1'b0, "R3 status cmd");
        xfer(8'h00, 1'b0, 1'b0, "R6 status disabled");
        // R4: hold low after the command ends the frame
        xfer(8'h03, 1'b0, 1'b0, "R4 short frame");
        xfer(8'h05, 1'b1, 1'b0, "R4 new command");
        xfer(8'h00, 1'b0, 1'b0, "R4 status frame");
        // R2: start while busy is ignored
        xfer(8'h05, 1'b1, 1'b0, "R2 poke command", 1'b1);
        xfer(8'h00, 1'b1, 1'b0, "R2 poke ignored", 1'b1);
        xfer(8'h00, 1'b0, 1'b0, "R2 frame intact");

        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule